// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Tick Sources

A memory-mapped watchdog for system supervision. It holds a 16-bit up-counter, a 16-bit compare value, a one-bit run flag and a six-bit control word. The control word picks one of three count sources and a power-of-four prescaler. Each source arrives as a single-cycle tick enable that is synchronous to the bus clock. While the watchdog runs, every prescaled tick of the chosen source advances the counter. When a prescaled tick arrives and the counter already equals the compare value, the block raises a system reset request. That request stays high until the block itself is reset.

Software keeps the system alive by writing zero to the counter. To reconfigure, software first stops the watchdog. It then loads the control word and the compare value, zeroes the counter and starts the watchdog again. None of these steps can produce a reset request. Reads return data one cycle after the read strobe, together with a valid flag.

Top module: `wdt_top`

## Requirements
- R1: After synchronous reset the run flag reads 0, the control word reads 0, the compare value reads 0xFFFF, the counter reads 0 and reset_req is low.
- R2: Registers are decoded on word-aligned byte offsets: 0x0 is the compare value, 0x4 is the run flag (bit 0), 0x8 is the counter and 0xC is the control word (bits [5:0]). Unused bits read as zero, and any other address reads zero. rd_data and rd_valid appear one cycle after rd_en.
- R3: Control bits [2:0] form a one-hot source select: bit 0 takes src_tick[0], bit 1 takes src_tick[1] and bit 2 takes src_tick[2]. Ticks on sources that are not selected do not advance the counter.
- R4: If no source bit is set, or if more than one is set, the counter does not advance.
- R5: Control bits [5:3] hold the prescale code. Codes 0 to 5 divide the source ticks by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 divide by 1024.
- R6: The prescaler count returns to zero whenever the run flag is 0 or the counter is written.
- R7: While the run flag is 0 the counter holds its value, and the run flag changes only when written.
- R8: A write to the counter loads the written value, so writing zero restarts the count. When a write and a tick land in the same cycle, the write wins.
- R9: When the run flag is 1 and a prescaled tick arrives while the counter equals the compare value, reset_req goes high on the next clock edge. It stays high until reset, and the counter stops advancing.
- R10: The sequence stop, load control, load compare, zero counter, start raises no reset request, even when the old count is above the new compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | rd_data is valid |
| src_tick | input | 3 | Tick enables of the three count sources |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The assertions check four things on every cycle. reset_req stays high once raised. It can only rise while the watchdog is running. The counter moves only on a prescaled tick or a write. The run flag changes only when it is written. They also check that the prescaler clears whenever the watchdog is stopped. The bench scenarios are needed for the behaviours that depend on counting and on mapping. These are the exact divide ratios of each prescale code, rejection of unselected or ambiguous sources, a write beating a tick in the same cycle, readback masking, and the reconfiguration sequence running without a spurious reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned SRC_N    = 3;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned MAX_CODE = 5;
  localparam int unsigned CTRL_W   = SRC_N + CODE_W;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_RUN  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned CW    = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cmp_q,
  output logic          run_q,
  output logic [CW-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '1;
      run_q  <= 1'b0;
      ctrl_q <= '0;
    end else if (wr_hit) begin
      case (wr_sel)
        SEL_CMP:  cmp_q  <= wr_data;
        SEL_RUN:  run_q  <= wr_data[0];
        SEL_CTRL: ctrl_q <= wr_data[CW-1:0];
        default:  ;
      endcase
    end
  end

  // R7
  run_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit && wr_sel == SEL_RUN) |=> $stable(run_q));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
  import wdt_pkg::*;
#(
  parameter int unsigned NSRC  = SRC_N,
  parameter int unsigned CDW   = CODE_W,
  parameter int unsigned CMAX  = MAX_CODE,
  localparam int unsigned PC_W = 2 * CMAX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [NSRC-1:0] src_sel,
  input  logic [NSRC-1:0] src_tick,
  input  logic [CDW-1:0]  code,
  output logic            tick_out
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] limit;
  logic [CDW-1:0]  code_eff;
  logic            src_hit;

  assign code_eff = (code > CDW'(CMAX)) ? CDW'(CMAX) : code;

  always_comb begin
    limit = '0;
    for (int k = 0; k <= int'(CMAX); k++) begin
      if (code_eff == CDW'(k)) limit = PC_W'((64'd1 << (2 * k)) - 64'd1);
    end
  end

  assign src_hit  = $onehot(src_sel) && |(src_sel & src_tick);
  assign tick_out = run && src_hit && (pc_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || clr) begin
      pc_q <= '0;
    end else if (src_hit) begin
      pc_q <= (pc_q >= limit) ? '0 : pc_q + 1'b1;
    end
  end

  // R6
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!run || clr) |=> pc_q == '0);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wr_val,
  input  logic [DW-1:0] cmp,
  output logic [DW-1:0] count_q,
  output logic          reset_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      reset_req <= 1'b0;
    end else if (wr) begin
      count_q <= wr_val;
    end else if (tick) begin
      if (count_q == cmp) reset_req <= 1'b1;
      else                count_q   <= count_q + 1'b1;
    end
  end

  // R9
  req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);
  // R9
  req_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(run));
  // R7
  count_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(count_q));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned NSRC   = SRC_N,
  parameter int unsigned CDW    = CODE_W,
  localparam int unsigned CW    = NSRC + CDW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  input  logic [NSRC-1:0]   src_tick,
  output logic              reset_req
);
  logic          addr_ok;
  reg_sel_e      sel;
  logic [DW-1:0] cmp_q, count_q, rd_mux;
  logic          run_q, cnt_wr, pre_tick;
  logic [CW-1:0] ctrl_q;

  assign sel     = reg_sel_e'(addr[3:2]);
  assign addr_ok = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
  assign cnt_wr  = wr_en && addr_ok && (sel == SEL_CNT);

  wdt_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_hit(wr_en && addr_ok), .wr_sel(sel),
    .wr_data(wr_data), .cmp_q(cmp_q), .run_q(run_q), .ctrl_q(ctrl_q)
  );

  wdt_prescale #(.NSRC(NSRC), .CDW(CDW)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .clr(cnt_wr),
    .src_sel(ctrl_q[NSRC-1:0]), .src_tick(src_tick),
    .code(ctrl_q[CW-1:NSRC]), .tick_out(pre_tick)
  );

  wdt_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .tick(pre_tick), .wr(cnt_wr),
    .wr_val(wr_data), .cmp(cmp_q), .count_q(count_q), .reset_req(reset_req)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        SEL_CMP:  rd_mux = cmp_q;
        SEL_RUN:  rd_mux = DW'(run_q);
        SEL_CNT:  rd_mux = count_q;
        SEL_CTRL: rd_mux = DW'(ctrl_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/test_wdt_top.sv
module test_wdt_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [2:0]  src_tick = '0;
  logic        reset_req;

  localparam logic [3:0] A_CMP = 4'h0, A_RUN = 4'h4, A_CNT = 4'h8, A_CTRL = 4'hC;

  int n_checks = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdt_top i_wdt_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .src_tick(src_tick), .reset_req(reset_req)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s: read %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    @(negedge clk); src_tick = m;
    repeat (n) @(negedge clk);
    src_tick = '0;
  endtask

  task automatic check_req(input logic e, input string t);
    @(negedge clk);
    n_checks++;
    if (reset_req !== e) begin
      n_fail++;
      $display("FAIL %s: reset_req %b expected %b", t, reset_req, e);
    end
  endtask

  task automatic setup(input logic [15:0] ctrl, input logic [15:0] cmp);
    wreg(A_RUN, 16'h0); wreg(A_CTRL, ctrl); wreg(A_CMP, cmp);
    wreg(A_CNT, 16'h0); wreg(A_RUN, 16'h1);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset values
    rreg(A_CMP, 16'hFFFF, "R1");
    rreg(A_RUN, 16'h0, "R1");
    rreg(A_CNT, 16'h0, "R1");
    rreg(A_CTRL, 16'h0, "R1");
    check_req(1'b0, "R1");

    // R3 / R9: source 0, divide by 1, compare 5
    setup(16'h0001, 16'd5);
    pulse(3'b001, 3); rreg(A_CNT, 16'd3, "R3");
    pulse(3'b010, 2); rreg(A_CNT, 16'd3, "R3 unselected");
    pulse(3'b001, 2); rreg(A_CNT, 16'd5, "R9 reach"); check_req(1'b0, "R9 before tick");
    pulse(3'b001, 1); check_req(1'b1, "R9 fire");
    rreg(A_CNT, 16'd5, "R9 hold");
    wreg(A_RUN, 16'h0); check_req(1'b1, "R9 sticky");

    // R8 keepalive and write priority
    do_reset();
    setup(16'h0001, 16'd3);
    pulse(3'b001, 2); rreg(A_CNT, 16'd2, "R8");
    wreg(A_CNT, 16'h0); rreg(A_CNT, 16'd0, "R8 kick");
    pulse(3'b001, 3); check_req(1'b0, "R8");
    @(negedge clk); wr_en = 1'b1; addr = A_CNT; wr_data = 16'h0; src_tick = 3'b001;
    @(negedge clk); wr_en = 1'b0; src_tick = '0;
    rreg(A_CNT, 16'd0, "R8 write wins");
    pulse(3'b001, 3); check_req(1'b0, "R8");
    wreg(A_CNT, 16'd2); rreg(A_CNT, 16'd2, "R8 load");

    // R5 / R6: source 1, divide by 4
    setup(16'h000A, 16'hFFFF);
    pulse(3'b010, 7); rreg(A_CNT, 16'd1, "R5 div4");
    pulse(3'b010, 1); rreg(A_CNT, 16'd2, "R5 div4");
    pulse(3'b010, 3); wreg(A_RUN, 16'h0); wreg(A_RUN, 16'h1);
    pulse(3'b010, 3); rreg(A_CNT, 16'd2, "R6 stop clears");
    wreg(A_CNT, 16'd0); pulse(3'b010, 3); wreg(A_CNT, 16'd0);
    pulse(3'b010, 3); rreg(A_CNT, 16'd0, "R6 write clears");
    pulse(3'b010, 1); rreg(A_CNT, 16'd1, "R6");

    // R5: divide by 16 on source 0, code 6 on source 2
    setup(16'h0011, 16'hFFFF);
    pulse(3'b001, 15); rreg(A_CNT, 16'd0, "R5 div16");
    pulse(3'b001, 1); rreg(A_CNT, 16'd1, "R5 div16");
    setup(16'h0034, 16'hFFFF);
    rreg(A_CTRL, 16'h0034, "R2 ctrl");
    pulse(3'b100, 1023); rreg(A_CNT, 16'd0, "R5 code6");
    pulse(3'b100, 1); rreg(A_CNT, 16'd1, "R5 code6");

    // R4 ambiguous / empty source
    setup(16'h0003, 16'hFFFF);
    pulse(3'b011, 5); rreg(A_CNT, 16'd0, "R4 two bits");
    setup(16'h0000, 16'hFFFF);
    pulse(3'b111, 5); rreg(A_CNT, 16'd0, "R4 none");

    // R7 stopped counter holds
    setup(16'h0001, 16'hFFFF);
    wreg(A_RUN, 16'h0);
    pulse(3'b001, 5); rreg(A_CNT, 16'd0, "R7");
    rreg(A_RUN, 16'h0, "R7");

    // R2 masking and unmapped address
    wreg(A_CTRL, 16'hFFFF); rreg(A_CTRL, 16'h003F, "R2 mask");
    wreg(A_RUN, 16'hFFFE); rreg(A_RUN, 16'h0, "R2 mask");
    rreg(4'h2, 16'h0, "R2 unmapped");
    rreg(A_CMP, 16'hFFFF, "R2 cmp");

    // R10 reconfigure sequence
    do_reset();
    setup(16'h0001, 16'hFFFF);
    pulse(3'b001, 10); rreg(A_CNT, 16'd10, "R10");
    setup(16'h0001, 16'd2);
    check_req(1'b0, "R10 no spurious");
    rreg(A_CNT, 16'd0, "R10");
    pulse(3'b001, 2); check_req(1'b0, "R10");
    pulse(3'b001, 1); check_req(1'b1, "R10 fires");

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule